// File: doc/BRIEF.md
# Flash Wide-Word Read Buffer

This block sits between a 32-bit bus read port and a flash array that delivers 128 bits per read. It holds one complete flash word together with its line address. A bus read whose address falls inside that buffered line is answered in the same cycle, with no flash access. Any other read starts a flash read, waits a software-programmable number of cycles, captures the 128-bit result into the buffer, and then answers from it.

Because one flash word covers four bus words, a stream of sequential 32-bit fetches touches the flash only once every four words. A flush input drops the buffered line, for example after the flash contents were changed by programming or erase. The next read then always goes back to the array. The wait count is held in a small register that is written and read back through dedicated ports.

Top module: `fwb_flash_rdbuf`

## Requirements
- R1: After reset the buffer holds no valid line, so the first read is a miss, and the wait-count register reads back its maximum value (all ones, 7 with the default 3-bit width).
- R2: A read whose line address (`bus_addr[19:4]`) equals the buffered line raises `bus_ack` in the same cycle and raises no `fl_rd`. Bits [3:2] of the address pick the 32-bit lane: lane n is `fl_rdata[32n+31:32n]` of the captured word.
- R3: A miss produces a single-cycle `fl_rd` pulse in the cycle after the request, with `fl_addr` equal to the request's line address. `fl_addr` is held for the whole fetch. `bus_ack` rises exactly W+2 cycles after the request was first presented, where W is the wait count.
- R4: The flash data is sampled in exactly one cycle: the cycle W cycles after the `fl_rd` cycle, which is the `fl_rd` cycle itself when W is 0.
- R5: A cycle with `ws_wr` high loads `ws_wdata` into the wait-count register, visible on `ws_value` from the next cycle. The new value governs the next fetch that starts.
- R6: Eight sequential word reads starting at a line boundary cause exactly two flash reads.
- R7: Only one line is kept. A read of another line replaces it, so returning to the first line is a miss again, while repeated reads of the same line never touch the flash.
- R8: `flush` drops the buffered line from the next cycle on. When it coincides with the capture cycle of a fetch, the captured data is discarded and the pending read is served by a second fetch, with latency 2W+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Read request, held until acknowledged |
| bus_addr | input | 20 | Byte address of the read |
| bus_ack | output | 1 | Read completes this cycle |
| bus_rdata | output | 32 | Selected 32-bit lane of the buffered word |
| ws_wr | input | 1 | Write strobe for the wait-count register |
| ws_wdata | input | 3 | New wait count |
| ws_value | output | 3 | Current wait count |
| flush | input | 1 | Invalidate the buffered line |
| fl_rd | output | 1 | One-cycle flash read strobe |
| fl_addr | output | 16 | Line address of the flash read |
| fl_rdata | input | 128 | Flash array read data |

## Verification
The in-RTL assertions watch, on every cycle, that the read strobe is a single pulse, that the flash address holds still during a fetch, that a hit never launches a flash read, that a flush clears the valid flag, that the timer stays busy until it expires, and that reset leaves the wait count at its maximum with no line held. Exact latency as a function of the programmed wait count, the single cycle in which the flash data is sampled, lane selection, the count of flash reads over a sequential run, and line replacement are shown only by the bench's scenarios. The bench's flash model presents valid data only in the intended sample cycle.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

    localparam int ADDR_W_DEF = 20;
    localparam int BUS_W_DEF  = 32;
    localparam int LINE_W_DEF = 128;
    localparam int WS_W_DEF   = 3;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } fwb_state_e;

    function automatic int ws_max(input int w);
        return (1 << w) - 1;
    endfunction

endpackage

// File: rtl/fwb_wait_timer.sv
module fwb_wait_timer #(
    parameter int WS_W = fwb_pkg::WS_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [WS_W-1:0] load_val,
    output logic            busy,
    output logic            done
);

    logic [WS_W-1:0] cnt_q;
    logic            busy_q;

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= load_val;
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R3
    timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && !start) |=> busy);

    // R4
    timer_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

endmodule

// File: rtl/fwb_line_store.sv
module fwb_line_store #(
    parameter int TAG_W  = 16,
    parameter int LINE_W = fwb_pkg::LINE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inv,
    input  logic              load,
    input  logic [TAG_W-1:0]  load_tag,
    input  logic [LINE_W-1:0] load_line,
    output logic              valid,
    output logic [TAG_W-1:0]  tag,
    output logic [LINE_W-1:0] line
);

    logic              valid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] line_q;

    assign valid = valid_q;
    assign tag   = tag_q;
    assign line  = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            line_q  <= '0;
        end else begin
            if (load) begin
                tag_q  <= load_tag;
                line_q <= load_line;
            end
            if (inv) begin
                valid_q <= 1'b0;
            end else if (load) begin
                valid_q <= 1'b1;
            end
        end
    end

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        inv |=> !valid);

    // R7
    load_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !inv) |=> (valid && tag == $past(load_tag)));

endmodule

// File: rtl/fwb_flash_rdbuf.sv
module fwb_flash_rdbuf
    import fwb_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int BUS_W  = BUS_W_DEF,
    parameter int LINE_W = LINE_W_DEF,
    parameter int WS_W   = WS_W_DEF,
    localparam int LANES     = LINE_W / BUS_W,
    localparam int LANE_BITS = $clog2(LANES),
    localparam int BYTE_BITS = $clog2(BUS_W / 8),
    localparam int OFF_BITS  = BYTE_BITS + LANE_BITS,
    localparam int TAG_W     = ADDR_W - OFF_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ack,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ws_wr,
    input  logic [WS_W-1:0]   ws_wdata,
    output logic [WS_W-1:0]   ws_value,
    input  logic              flush,
    output logic              fl_rd,
    output logic [TAG_W-1:0]  fl_addr,
    input  logic [LINE_W-1:0] fl_rdata
);

    localparam logic [WS_W-1:0] WS_RESET = WS_W'(ws_max(WS_W));

    fwb_state_e        state_q;
    logic [TAG_W-1:0]  pend_tag_q;
    logic              fl_rd_q;
    logic [WS_W-1:0]   ws_q;

    logic              buf_valid;
    logic [TAG_W-1:0]  buf_tag;
    logic [LINE_W-1:0] buf_line;
    logic              tmr_busy;
    logic              tmr_done;

    logic [TAG_W-1:0]     req_tag;
    logic [LANE_BITS-1:0] lane_idx;
    logic                 hit;
    logic                 miss_start;
    logic                 capture;
    logic [BUS_W-1:0]     lane_data [LANES];

    assign req_tag    = bus_addr[ADDR_W-1:OFF_BITS];
    assign lane_idx   = bus_addr[BYTE_BITS +: LANE_BITS];
    assign hit        = buf_valid && (buf_tag == req_tag);
    assign miss_start = (state_q == ST_IDLE) && bus_req && !hit;
    assign capture    = (state_q == ST_FETCH) && tmr_done;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign lane_data[g] = buf_line[g*BUS_W +: BUS_W];
        end
    endgenerate

    assign bus_ack   = (state_q == ST_IDLE) && bus_req && hit;
    assign bus_rdata = lane_data[lane_idx];
    assign ws_value  = ws_q;
    assign fl_rd     = fl_rd_q;
    assign fl_addr   = pend_tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            pend_tag_q <= '0;
            fl_rd_q    <= 1'b0;
            ws_q       <= WS_RESET;
        end else begin
            fl_rd_q <= miss_start;
            if (ws_wr) begin
                ws_q <= ws_wdata;
            end
            case (state_q)
                ST_IDLE: begin
                    if (miss_start) begin
                        state_q    <= ST_FETCH;
                        pend_tag_q <= req_tag;
                    end
                end
                ST_FETCH: begin
                    if (tmr_done) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    fwb_wait_timer #(
        .WS_W(WS_W)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .start    (miss_start),
        .load_val (ws_q),
        .busy     (tmr_busy),
        .done     (tmr_done)
    );

    fwb_line_store #(
        .TAG_W (TAG_W),
        .LINE_W(LINE_W)
    ) store_i (
        .clk       (clk),
        .rst       (rst),
        .inv       (flush),
        .load      (capture),
        .load_tag  (pend_tag_q),
        .load_line (fl_rdata),
        .valid     (buf_valid),
        .tag       (buf_tag),
        .line      (buf_line)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (ws_value == WS_RESET && !buf_valid));

    // R2
    hit_no_flash_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !fl_rd);

    // R3
    fl_rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fl_rd |=> !fl_rd);

    // R3
    fetch_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH && $past(state_q) == ST_FETCH) |-> $stable(fl_addr));

    // R3
    fetch_has_timer_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |-> tmr_busy);

endmodule

// File: tb/fwb_flash_rdbuf_tb_top.sv
module fwb_flash_rdbuf_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_req;
    logic [19:0]  bus_addr;
    logic         bus_ack;
    logic [31:0]  bus_rdata;
    logic         ws_wr;
    logic [2:0]   ws_wdata;
    logic [2:0]   ws_value;
    logic         flush;
    logic         fl_rd;
    logic [15:0]  fl_addr;
    logic [127:0] fl_rdata;

    int checks   = 0;
    int failures = 0;
    int fl_cnt   = 0;
    int since_rd = 255;
    int bench_ws = 7;
    int cycles   = 0;
    logic [15:0] last_fl_addr = '0;

    always #10 clk = ~clk;

    fwb_flash_rdbuf dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_req  (bus_req),
        .bus_addr (bus_addr),
        .bus_ack  (bus_ack),
        .bus_rdata(bus_rdata),
        .ws_wr    (ws_wr),
        .ws_wdata (ws_wdata),
        .ws_value (ws_value),
        .flush    (flush),
        .fl_rd    (fl_rd),
        .fl_addr  (fl_addr),
        .fl_rdata (fl_rdata)
    );

    function automatic logic [31:0] exp_word(input int addr);
        return 32'h1000_0000 + 32'((addr >> 4) * 4 + ((addr >> 2) & 3));
    endfunction

    // Flash model: correct data only in the intended sample cycle (R4)
    always_comb begin
        logic good;
        good = fl_rd ? (bench_ws == 0) : (since_rd == bench_ws - 1);
        for (int i = 0; i < 4; i++) begin
            fl_rdata[i*32 +: 32] = good ? exp_word(int'(fl_addr) * 16 + i * 4)
                                        : 32'hDEAD_BEEF;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (fl_rd) begin
            fl_cnt       <= fl_cnt + 1;
            since_rd     <= 0;
            last_fl_addr <= fl_addr;
        end else if (since_rd < 255) begin
            since_rd <= since_rd + 1;
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input int addr, input int flush_at,
                           output logic [31:0] data, output int lat, output int nfl);
        int fl0;
        fl0 = fl_cnt;
        lat = 0;
        @(negedge clk);
        bus_req  = 1'b1;
        bus_addr = 20'(addr);
        forever begin
            #1;
            if (bus_ack) break;
            @(posedge clk);
            @(negedge clk);
            lat++;
            flush = (lat == flush_at);
            if (lat > 200) begin
                failures++;
                $display("FAIL watchdog: read hung actual=%0d expected<=200", lat);
                break;
            end
        end
        flush = 1'b0;
        data = bus_rdata;
        nfl  = fl_cnt - fl0;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic set_ws(input int w);
        @(negedge clk);
        ws_wr    = 1'b1;
        ws_wdata = 3'(w);
        @(negedge clk);
        ws_wr    = 1'b0;
        bench_ws = w;
        check(ws_value == 3'(w), "R5 wait-count readback", ws_value, w);
    endtask

    task automatic t_reset;
        logic [31:0] d; int lat; int nfl;
        check(ws_value == 3'd7, "R1 reset wait count", ws_value, 7);
        check(bus_ack == 1'b0 && fl_rd == 1'b0, "R1 idle outputs", {bus_ack, fl_rd}, 0);
        do_read(20'h00040, -1, d, lat, nfl);
        check(lat == 9, "R1 first read misses (W=7)", lat, 9);
        check(nfl == 1, "R1 one flash read", nfl, 1);
        check(d == exp_word(20'h00040), "R4 data at W=7", d, exp_word(20'h00040));
    endtask

    task automatic t_miss_then_hits;
        logic [31:0] d; int lat; int nfl;
        set_ws(1);
        do_read(20'h12348, -1, d, lat, nfl);
        check(lat == 3, "R3 miss latency W=1", lat, 3);
        check(last_fl_addr == 16'h1234, "R3 flash line address", last_fl_addr, 16'h1234);
        check(d == exp_word(20'h12348), "R4 data W=1", d, exp_word(20'h12348));
        for (int i = 0; i < 4; i++) begin
            do_read(20'h12340 + i * 4, -1, d, lat, nfl);
            check(lat == 0 && nfl == 0, "R2 hit zero wait no flash", lat * 16 + nfl, 0);
            check(d == exp_word(20'h12340 + i * 4), "R2 lane select", d, exp_word(20'h12340 + i * 4));
        end
    endtask

    task automatic t_wait_counts;
        logic [31:0] d; int lat; int nfl;
        set_ws(0);
        do_read(20'h0A000, -1, d, lat, nfl);
        check(lat == 2, "R3 miss latency W=0", lat, 2);
        check(d == exp_word(20'h0A000), "R4 data W=0", d, exp_word(20'h0A000));
        set_ws(3);
        do_read(20'h0B00C, -1, d, lat, nfl);
        check(lat == 5, "R5 new W=3 used by next fetch", lat, 5);
        check(d == exp_word(20'h0B00C), "R4 data W=3", d, exp_word(20'h0B00C));
    endtask

    task automatic t_sequential;
        logic [31:0] d; int lat; int nfl; int tot;
        set_ws(2);
        tot = 0;
        for (int i = 0; i < 8; i++) begin
            do_read(20'h20000 + i * 4, -1, d, lat, nfl);
            tot += nfl;
            check(d == exp_word(20'h20000 + i * 4), "R6 sequential data", d, exp_word(20'h20000 + i * 4));
        end
        check(tot == 2, "R6 two flash reads for eight words", tot, 2);
    endtask

    task automatic t_single_entry;
        logic [31:0] d; int lat; int nfl;
        do_read(20'h30000, -1, d, lat, nfl);
        do_read(20'h30004, -1, d, lat, nfl);
        check(nfl == 0, "R7 repeat same line no flash", nfl, 0);
        do_read(20'h30010, -1, d, lat, nfl);
        check(nfl == 1, "R7 other line fetched", nfl, 1);
        do_read(20'h30008, -1, d, lat, nfl);
        check(nfl == 1 && lat == 4, "R7 first line evicted", nfl * 16 + lat, 20);
        check(d == exp_word(20'h30008), "R7 refetched data", d, exp_word(20'h30008));
    endtask

    task automatic t_flush;
        logic [31:0] d; int lat; int nfl;
        do_read(20'h40004, -1, d, lat, nfl);
        do_read(20'h40004, -1, d, lat, nfl);
        check(nfl == 0, "R8 hit before flush", nfl, 0);
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        do_read(20'h40004, -1, d, lat, nfl);
        check(nfl == 1 && lat == 4, "R8 miss after flush", nfl * 16 + lat, 20);
        do_read(20'h5000C, 3, d, lat, nfl);
        check(lat == 8, "R8 flush at capture refetch latency", lat, 8);
        check(nfl == 2, "R8 flush at capture two flash reads", nfl, 2);
        check(d == exp_word(20'h5000C), "R8 data after refetch", d, exp_word(20'h5000C));
    endtask

    initial begin
        rst      = 1'b1;
        bus_req  = 1'b0;
        bus_addr = '0;
        ws_wr    = 1'b0;
        ws_wdata = '0;
        flush    = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_miss_then_hits();
        t_wait_counts();
        t_sequential();
        t_single_entry();
        t_flush();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule